// File: doc/BRIEF.md
# APB to Byte-Wide Peripheral Bridge

This block connects a 32-bit APB slave port to an external 8-bit multiplexed address/data bus, such as a bus for boot flash and other slow devices. Any access wider than a byte goes out as a series of byte cycles. First the address goes out one byte per cycle with an address-latch strobe. Then the data bytes follow, one per cycle, each with a read or write strobe. Each strobe lasts a fixed number of core clocks, set by the parameter `STROBE_CLKS`.

Two settings control the bus, and they are independent. The first is a width setting. It gives the number of address bytes per access and the number of data bytes per write, each from 1 to 4. The second is a read-mode bit. In byte mode a read makes one external byte cycle and returns that byte on the low lane. In word mode a read makes four external byte reads from consecutive addresses and packs the bytes little-endian into one 32-bit result. Word mode is the reset default.

APB address bit 31 selects between the two configuration registers (bit 31 = 1, bit 2 picks the register) and the external window (bit 31 = 0). For an external access the APB address is sent as-is.

Top module: `apb_narrow_bridge`

## Requirements
- R1: After reset the width register reads 0x0000_0033 (4 address bytes, 4 data bytes), the read-mode register reads 0 (word mode), and ext_ale, ext_rd, ext_wr and pready are all low.
- R2: The width register is at APB address 0x8000_0000. Bits 1:0 hold the address byte count minus one and bits 5:4 hold the write data byte count minus one. All other bits read as zero. A register access completes with pready high in its first access-phase cycle.
- R3: The read-mode register is at APB address 0x8000_0004 and uses only bit 0. Bits 31:1 read as zero, and writes to them have no effect.
- R4: Each external access begins with N address bytes, where N comes from the width register. The address is driven on ext_ad_o with ext_ale high, most significant of the low N bytes first.
- R5: Every address, read or write byte cycle keeps its strobe high for exactly STROBE_CLKS clocks. Byte cycles follow one another with no gap.
- R6: An external write sends D data bytes with ext_wr and ext_ad_oe high, starting with pwdata bits 7:0 and moving up. D comes from the width register.
- R7: With read-mode bit 0 = 1, a read makes one address phase and one read byte cycle. It returns the byte on prdata bits 7:0, with bits 31:8 at zero.
- R8: With read-mode bit 0 = 0, a read makes four address-plus-read sequences at addresses A, A+1, A+2 and A+3, where A is the APB address with bits 1:0 cleared. The byte from A is returned on prdata bits 7:0 and the byte from A+3 on bits 31:24.
- R9: For an external transfer pready stays low until the last byte cycle ends, then goes high for one cycle. pslverr is always low.
- R10: At most one of ext_ale, ext_rd and ext_wr is high at a time, and ext_ad_oe is low while ext_rd is high. All strobes are low between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Core clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 32 | APB address; bit 31 selects the registers |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error, always low |
| ext_ad_o | output | 8 | Multiplexed address/data out |
| ext_ad_i | input | 8 | Data in from the external bus |
| ext_ad_oe | output | 1 | Bridge drives the external bus |
| ext_ale | output | 1 | Address-latch strobe |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |

## Verification
The hardest case to reach is a word-mode read where the four sub-accesses each rebuild their address from the same base, combined with a short address width. A wrong lane index or a carry into a higher byte only shows up when the base sits near the top of a narrow address range. To reach it, the stimulus sets a one-byte address width and reads from an address whose low bits are set. The bench's device model returns a different byte for each address, so each packed lane can be traced back to the address that produced it. The stimulus also switches modes and widths between transfers, which shows that each transfer uses the settings in force when it starts.

// File: rtl/apb_narrow_bridge.sv
module apb_narrow_bridge #(
  parameter int STROBE_CLKS = 2
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [31:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pready,
  output logic        pslverr,
  output logic [7:0]  ext_ad_o,
  input  logic [7:0]  ext_ad_i,
  output logic        ext_ad_oe,
  output logic        ext_ale,
  output logic        ext_rd,
  output logic        ext_wr
);
  localparam int TW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_DONE} st_t;

  st_t          st;
  logic [1:0]   acyc_m1, dcyc_m1;
  logic         rmode;
  logic [31:0]  addr_q, wdata_q, rdata_q;
  logic         wr_q, byte_q;
  logic [TW-1:0] tick;
  logic [1:0]   bcnt, sub;

  wire        reg_sel   = paddr[31];
  wire        acc       = psel & penable;
  wire        idle      = (st == S_IDLE);
  wire        reg_acc   = acc & reg_sel & idle;
  wire        start     = acc & ~reg_sel & idle;
  wire        last_tick = (tick == TW'(STROBE_CLKS - 1));
  wire [1:0]  aidx      = acyc_m1 - bcnt;
  wire [1:0]  lane      = byte_q ? 2'd0 : sub;
  wire [31:0] addr_seq  = (wr_q | byte_q) ? addr_q : {addr_q[31:2], sub};
  wire [7:0]  abyte     = addr_seq[{aidx, 3'b000} +: 8];
  wire [7:0]  wbyte     = wdata_q[{bcnt, 3'b000} +: 8];
  wire [31:0] regval    = paddr[2] ? {31'd0, rmode} : {26'd0, dcyc_m1, 2'b00, acyc_m1};

  assign ext_ale   = (st == S_ADDR);
  assign ext_rd    = (st == S_DATA) & ~wr_q;
  assign ext_wr    = (st == S_DATA) & wr_q;
  assign ext_ad_oe = ext_ale | ext_wr;
  assign ext_ad_o  = ext_ale ? abyte : (ext_wr ? wbyte : 8'h00);
  assign pready    = reg_acc | (st == S_DONE);
  assign pslverr   = 1'b0;
  assign prdata    = reg_sel ? regval : rdata_q;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      acyc_m1 <= 2'd3;
      dcyc_m1 <= 2'd3;
      rmode   <= 1'b0;
    end else if (reg_acc && pwrite) begin
      if (paddr[2]) rmode <= pwdata[0];
      else begin
        acyc_m1 <= pwdata[1:0];
        dcyc_m1 <= pwdata[5:4];
      end
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      byte_q  <= 1'b0;
      tick    <= '0;
      bcnt    <= '0;
      sub     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr_q  <= paddr;
          wdata_q <= pwdata;
          wr_q    <= pwrite;
          byte_q  <= rmode;
          rdata_q <= '0;
          tick    <= '0;
          bcnt    <= '0;
          sub     <= '0;
          st      <= S_ADDR;
        end
        S_ADDR: if (last_tick) begin
          tick <= '0;
          if (bcnt == acyc_m1) begin
            bcnt <= '0;
            st   <= S_DATA;
          end else bcnt <= bcnt + 2'd1;
        end else tick <= tick + TW'(1);
        S_DATA: if (last_tick) begin
          tick <= '0;
          if (wr_q) begin
            if (bcnt == dcyc_m1) st <= S_DONE;
            else bcnt <= bcnt + 2'd1;
          end else begin
            rdata_q[{lane, 3'b000} +: 8] <= ext_ad_i;
            if (byte_q || sub == 2'd3) st <= S_DONE;
            else begin
              sub <= sub + 2'd1;
              st  <= S_ADDR;
            end
          end
        end else tick <= tick + TW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nb_chk #(
  parameter int STROBE_CLKS = 2
) (
  input logic        pclk,
  input logic        presetn,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [31:0] paddr,
  input logic [31:0] prdata,
  input logic        pready,
  input logic        pslverr,
  input logic        ext_ad_oe,
  input logic        ext_ale,
  input logic        ext_rd,
  input logic        ext_wr
);
  logic [7:0] rd_len;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rd_len <= '0;
    else if (ext_rd) rd_len <= rd_len + 8'd1;
    else rd_len <= '0;
  end

  a_r10_one_strobe: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0({ext_ale, ext_rd, ext_wr}));
  a_r10_no_drive_on_read: assert property (@(posedge pclk) disable iff (!presetn)
    ext_rd |-> !ext_ad_oe);
  a_r9_no_error: assert property (@(posedge pclk) disable iff (!presetn)
    !pslverr);
  a_r9_ready_pulse: assert property (@(posedge pclk) disable iff (!presetn)
    (pready && !paddr[31]) |=> !pready);
  a_r9_ready_in_access: assert property (@(posedge pclk) disable iff (!presetn)
    pready |-> (psel && penable));
  a_r5_read_strobe_len: assert property (@(posedge pclk) disable iff (!presetn)
    $fell(ext_rd) |-> (rd_len == 8'(STROBE_CLKS)));
  a_r3_reserved_zero: assert property (@(posedge pclk) disable iff (!presetn)
    (pready && !pwrite && paddr[31] && paddr[2]) |-> (prdata[31:1] == 31'd0));
endmodule

bind apb_narrow_bridge nb_chk #(.STROBE_CLKS(STROBE_CLKS)) u_chk (.*);

// File: tb/tb_apb_narrow_bridge.sv
`timescale 1ns/1ps
module tb_apb_narrow_bridge;
  localparam int STB = 2;
  localparam logic [31:0] A_WID = 32'h8000_0000;
  localparam logic [31:0] A_RMD = 32'h8000_0004;

  logic clk = 0, rstn = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [31:0] paddr = 0, pwdata = 0, prdata;
  logic pready, pslverr;
  logic [7:0] ext_ad_o, ext_ad_i;
  logic ext_ad_oe, ext_ale, ext_rd, ext_wr;

  int n_tests = 0, n_fail = 0;
  int cur_na = 4;

  always #2.5 clk = ~clk;

  apb_narrow_bridge #(.STROBE_CLKS(STB)) dut (
    .pclk(clk), .presetn(rstn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .ext_ad_o(ext_ad_o), .ext_ad_i(ext_ad_i), .ext_ad_oe(ext_ad_oe),
    .ext_ale(ext_ale), .ext_rd(ext_rd), .ext_wr(ext_wr));

  function automatic logic [31:0] amask(input int na);
    return (na >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * na)) - 32'd1);
  endfunction

  function automatic logic [7:0] fdev(input logic [31:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h5A;
  endfunction

  // device model
  logic [31:0] sh = 0;
  int acnt = 0, wcnt = 0, rcnt = 0;
  int nale = 0, nw = 0, nrd = 0;
  logic [7:0]  wlog [0:63];
  logic [31:0] rlog [0:63];

  assign ext_ad_i = ext_rd ? fdev(sh & amask(cur_na)) : 8'h00;

  always @(posedge clk) begin
    if (ext_ale) begin
      if (acnt == STB - 1) begin
        sh <= {sh[23:0], ext_ad_o};
        acnt <= 0;
        nale <= nale + 1;
      end else acnt <= acnt + 1;
    end else acnt <= 0;
    if (ext_wr) begin
      if (wcnt == STB - 1) begin
        wlog[nw % 64] <= ext_ad_o;
        nw <= nw + 1;
        wcnt <= 0;
      end else wcnt <= wcnt + 1;
    end else wcnt <= 0;
    if (ext_rd) begin
      if (rcnt == STB - 1) begin
        rlog[nrd % 64] <= sh & amask(cur_na);
        nrd <= nrd + 1;
        rcnt <= 0;
      end else rcnt <= rcnt + 1;
    end else rcnt <= 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apb(input logic wr, input logic [31:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int cyc);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1;
    cyc = 0;
    while (!pready && cyc < 2000) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = prdata;
    chk(pslverr == 1'b0, "R9 pslverr", {31'd0, pslverr}, 0);
    @(negedge clk);
    psel = 0; penable = 0;
    #1;
    chk(pready == 1'b0, "R9 single ready", {31'd0, pready}, 0);
    chk(!ext_ale && !ext_rd && !ext_wr, "R10 idle strobes",
        {29'd0, ext_ale, ext_rd, ext_wr}, 0);
  endtask

  task automatic t_reset;
    logic [31:0] r; int c;
    chk(!ext_ale && !ext_rd && !ext_wr && !pready, "R1 outputs at reset",
        {28'd0, ext_ale, ext_rd, ext_wr, pready}, 0);
    apb(0, A_WID, 0, r, c);
    chk(r == 32'h33, "R1 width reset", r, 32'h33);
    apb(0, A_RMD, 0, r, c);
    chk(r == 0, "R1 read-mode reset", r, 0);
  endtask

  task automatic t_regs;
    logic [31:0] r; int c;
    apb(1, A_WID, 32'hFFFF_FF12, r, c);
    chk(c == 0, "R2 register access no wait", c, 0);
    apb(0, A_WID, 0, r, c);
    chk(r == 32'h12, "R2 width fields", r, 32'h12);
    apb(1, A_RMD, 32'hFFFF_FFFE, r, c);
    apb(0, A_RMD, 0, r, c);
    chk(r == 0, "R3 reserved ignored", r, 0);
    apb(1, A_RMD, 32'hFFFF_FFFF, r, c);
    apb(0, A_RMD, 0, r, c);
    chk(r == 1, "R3 bit0 only", r, 1);
  endtask

  task automatic t_write(input int na, input int nd, input logic [31:0] a, input logic [31:0] d);
    logic [31:0] r; int c, w0, a0;
    cur_na = na;
    apb(1, A_WID, ((nd - 1) << 4) | (na - 1), r, c);
    w0 = nw; a0 = nale;
    apb(1, a, d, r, c);
    chk(c == 1 + STB * (na + nd), "R9 write wait cycles", c, 1 + STB * (na + nd));
    chk(nale - a0 == na, "R4 address byte count", nale - a0, na);
    chk((sh & amask(na)) == (a & amask(na)), "R4 address order", sh & amask(na), a & amask(na));
    chk(nw - w0 == nd, "R6 data byte count", nw - w0, nd);
    for (int i = 0; i < nd; i++)
      chk(wlog[(w0 + i) % 64] == d[8*i +: 8], "R6 write byte order", wlog[(w0 + i) % 64], d[8*i +: 8]);
  endtask

  task automatic t_word_read(input int na, input logic [31:0] a);
    logic [31:0] r, exp, b; int c, r0;
    cur_na = na;
    apb(1, A_WID, 32'h30 | (na - 1), r, c);
    apb(1, A_RMD, 0, r, c);
    b = {a[31:2], 2'b00};
    exp = 0;
    for (int i = 0; i < 4; i++) exp[8*i +: 8] = fdev((b + i) & amask(na));
    r0 = nrd;
    apb(0, a, 0, r, c);
    chk(c == 1 + 4 * STB * (na + 1), "R8 word read cycles", c, 1 + 4 * STB * (na + 1));
    chk(nrd - r0 == 4, "R8 four reads", nrd - r0, 4);
    for (int i = 0; i < 4; i++)
      chk(rlog[(r0 + i) % 64] == ((b + i) & amask(na)), "R8 consecutive addresses",
          rlog[(r0 + i) % 64], (b + i) & amask(na));
    chk(r == exp, "R8 little-endian pack", r, exp);
  endtask

  task automatic t_byte_read(input int na, input logic [31:0] a);
    logic [31:0] r, exp; int c, r0;
    cur_na = na;
    apb(1, A_WID, 32'h00 | (na - 1), r, c);
    apb(1, A_RMD, 1, r, c);
    exp = {24'd0, fdev(a & amask(na))};
    r0 = nrd;
    apb(0, a, 0, r, c);
    chk(c == 1 + STB * (na + 1), "R7 byte read cycles", c, 1 + STB * (na + 1));
    chk(nrd - r0 == 1, "R7 single read", nrd - r0, 1);
    chk(rlog[r0 % 64] == (a & amask(na)), "R4 byte read address", rlog[r0 % 64], a & amask(na));
    chk(r == exp, "R7 low lane data", r, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!pready && !ext_ale, "R1 in reset", {30'd0, pready, ext_ale}, 0);
    rstn = 1;
    t_reset();
    t_regs();
    t_write(4, 4, 32'h1234_5678, 32'hA1B2_C3D4);
    t_write(2, 1, 32'h0000_9ABC, 32'h0000_0055);
    t_write(3, 3, 32'h0012_3456, 32'h00C0_FFEE);
    t_word_read(4, 32'h0000_1237);
    t_byte_read(3, 32'h00AB_CDEF);
    t_byte_read(1, 32'h0000_007E);
    t_word_read(1, 32'h0000_00FD);
    t_word_read(2, 32'h0000_3FFE);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule